// File: doc/BRIEF.md
# Receive-Only Word Request Counter

This block runs the bit-level receive path of a serial master when the transmitter is off. Software writes a byte count into a request input. The block then enables the shift clock and gathers the incoming bits, most significant bit first, into 32-bit words. It does this whatever word width is programmed elsewhere. A remaining-byte counter drops by one for each complete byte, and each finished word goes to the receive FIFO together with a count of its valid bytes.

When the request runs out in the middle of a word, the partial word is pushed right away. It is right-aligned, with the earliest byte in the highest valid lane and the newest byte in bits 7:0. The bytes-valid count tells the reader how many lanes to use. Software should keep each request to FIFO depth times four bytes and issue further requests for the rest. The shift clock is held off while the FIFO reports full.

Top module: `rxq_request_top`

## Requirements
- R1: After reset, `todo_bytes` is 0, `shift_en` is low, and `fifo_push` and `rx_done` are both low.
- R2: A `req_wr` pulse with a nonzero `req_bytes` loads the 16-bit count into `todo_bytes` on that edge and raises `shift_en`. A `req_wr` with `req_bytes` equal to 0 leaves `todo_bytes` unchanged.
- R3: Each group of 8 accepted bits lowers `todo_bytes` by exactly 1, on the edge that accepts the eighth bit.
- R4: Bits are taken most significant bit first. A full word holds 4 bytes, and the first byte received lands in bits 31:24.
- R5: `fifo_bytes_vld` is valid alongside `fifo_push` and is 4 for a full word. For a final partial word it is 1, 2 or 3.
- R6: In a partial final word, the first byte sits in the highest valid lane, the last byte sits in bits 7:0, and the unused upper lanes read 0.
- R7: While `fifo_full` is high, `shift_en` is low. Bits offered on `rx_bit_vld` while `shift_en` is low are ignored.
- R8: A nonzero request written while a transfer is active replaces the remaining count. Bytes already gathered into the current word are kept.
- R9: `rx_done` pulses for one cycle, once per exhausted request, on the same edge where `todo_bytes` reaches 0.
- R10: `fifo_push` is a one-cycle pulse registered on the edge that accepts either the 32nd bit of a word or the last requested bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_wr | input | 1 | Write strobe for a byte-count request |
| req_bytes | input | 16 | Requested byte count |
| shift_en | output | 1 | Enables the shift clock for the serial engine |
| rx_bit_vld | input | 1 | A received bit is offered this cycle |
| rx_bit | input | 1 | The received bit value |
| fifo_full | input | 1 | Receive FIFO cannot take another word |
| fifo_push | output | 1 | Write strobe to the receive FIFO |
| fifo_word | output | 32 | Word written to the FIFO |
| fifo_bytes_vld | output | 3 | Count of valid bytes in `fifo_word`, from 1 to 4 |
| todo_bytes | output | 16 | Bytes requested but not yet received |
| rx_done | output | 1 | One-cycle pulse when the request is exhausted |

## Verification
Two kinds of internal fault can occur here. A wrong bit counter or lane counter shows up as a word pushed at the wrong edge, or as data shifted by whole bits or bytes. Either appears at `fifo_push` within one word time of the fault. A wrong remaining count shows at `todo_bytes` on the very next byte boundary, and as a missing, early or doubled `rx_done` pulse. The directed scenarios cover full-word runs, each partial-word length, a FIFO stall with bits offered, a mid-transfer replacement, and a zero write. Each scenario samples the outputs one half-cycle after the accepting edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_CNT_W      = 16;
  localparam int RXQ_BYTE_W     = 8;
  localparam int RXQ_WORD_BYTES = 4;
  localparam int RXQ_WORD_W     = RXQ_BYTE_W * RXQ_WORD_BYTES;
  localparam int RXQ_BV_W       = $clog2(RXQ_WORD_BYTES + 1);
  localparam int RXQ_BIT_IDX_W  = $clog2(RXQ_BYTE_W);

  typedef struct packed {
    logic [RXQ_WORD_W-1:0] data;
    logic [RXQ_BV_W-1:0]   nbytes;
  } rxq_word_t;

  // Keep the low nbytes byte lanes of a word, clear the rest.
  function automatic logic [RXQ_WORD_W-1:0] rxq_lane_mask(
    input logic [RXQ_BV_W-1:0] nbytes);
    logic [RXQ_WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < RXQ_WORD_BYTES; k++) begin
      if (k < int'(nbytes)) m[k*RXQ_BYTE_W +: RXQ_BYTE_W] = '1;
    end
    return m;
  endfunction

  // Remaining-count update: a load wins over a byte completion.
  function automatic logic [RXQ_CNT_W-1:0] rxq_todo_next(
    input logic [RXQ_CNT_W-1:0] todo,
    input logic                 load,
    input logic [RXQ_CNT_W-1:0] count,
    input logic                 byte_done);
    if (load)                          return count;
    else if (byte_done && todo != '0)  return todo - 1'b1;
    else                               return todo;
  endfunction
endpackage

// File: rtl/rxq_req_ctrl.sv
module rxq_req_ctrl
  import rxq_pkg::*;
#(
  parameter int CNT_W = RXQ_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [CNT_W-1:0] req_bytes,
  input  logic             byte_done,
  output logic [CNT_W-1:0] todo,
  output logic             busy,
  output logic             req_load,
  output logic             final_byte,
  output logic             done_pulse
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] todo_q;

  assign req_load   = req_wr && (req_bytes != '0);
  assign final_byte = byte_done && (todo_q == ONE) && !req_load;
  assign busy       = (todo_q != '0);
  assign todo       = todo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      todo_q     <= '0;
      done_pulse <= 1'b0;
    end else begin
      todo_q     <= CNT_W'(rxq_todo_next(RXQ_CNT_W'(todo_q), req_load,
                                         RXQ_CNT_W'(req_bytes), byte_done));
      done_pulse <= final_byte;
    end
  end

  AST_TODO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !req_load |=> todo_q == $past(todo_q) - ONE); // R3
  AST_REQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    req_load |=> todo_q == $past(req_bytes)); // R8
  AST_ZERO_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && req_bytes == '0 && !byte_done |=> $stable(todo_q)); // R2
  AST_NO_BYTE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    todo_q == '0 |-> !byte_done); // R7
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> todo_q == '0); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R9
endmodule

// File: rtl/rxq_assembler.sv
module rxq_assembler
  import rxq_pkg::*;
#(
  parameter int WORD_BYTES = RXQ_WORD_BYTES,
  parameter int BYTE_W     = RXQ_BYTE_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      bit_in,
  input  logic      final_byte,
  output logic      byte_done,
  output logic      push,
  output rxq_word_t word
);
  localparam int WORD_W = WORD_BYTES * BYTE_W;
  localparam int BIDX_W = $clog2(BYTE_W);
  localparam logic [BIDX_W-1:0]   LAST_BIT  = BIDX_W'(BYTE_W - 1);
  localparam logic [RXQ_BV_W-1:0] LAST_LANE = RXQ_BV_W'(WORD_BYTES - 1);

  logic [WORD_W-1:0]   acc_q;
  logic [WORD_W-1:0]   acc_next;
  logic [BIDX_W-1:0]   bit_cnt_q;
  logic [RXQ_BV_W-1:0] lane_cnt_q;
  logic [RXQ_BV_W-1:0] lanes_filled;
  logic                word_full;
  logic                flush;

  assign acc_next     = {acc_q[WORD_W-2:0], bit_in};
  assign byte_done    = take && (bit_cnt_q == LAST_BIT);
  assign word_full    = byte_done && (lane_cnt_q == LAST_LANE);
  assign flush        = word_full || final_byte;
  assign lanes_filled = lane_cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      bit_cnt_q  <= '0;
      lane_cnt_q <= '0;
      push       <= 1'b0;
      word       <= '0;
    end else begin
      push <= flush;
      if (take) begin
        acc_q     <= acc_next;
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      if (flush) begin
        word.data   <= acc_next & RXQ_WORD_W'(rxq_lane_mask(lanes_filled));
        word.nbytes <= lanes_filled;
        lane_cnt_q  <= '0;
      end else if (byte_done) begin
        lane_cnt_q  <= lanes_filled;
      end
    end
  end

  AST_BV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (word.nbytes >= 1 && word.nbytes <= RXQ_BV_W'(WORD_BYTES))); // R5
  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push); // R10
  AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lane_cnt_q < RXQ_BV_W'(WORD_BYTES)); // R4
  AST_FINAL_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    final_byte |-> byte_done); // R10
endmodule

// File: rtl/rxq_request_top.sv
module rxq_request_top
  import rxq_pkg::*;
#(
  parameter int CNT_W = RXQ_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_wr,
  input  logic [CNT_W-1:0]      req_bytes,
  output logic                  shift_en,
  input  logic                  rx_bit_vld,
  input  logic                  rx_bit,
  input  logic                  fifo_full,
  output logic                  fifo_push,
  output logic [RXQ_WORD_W-1:0] fifo_word,
  output logic [RXQ_BV_W-1:0]   fifo_bytes_vld,
  output logic [CNT_W-1:0]      todo_bytes,
  output logic                  rx_done
);
  logic      busy;
  logic      take;
  logic      byte_done;
  logic      req_load;
  logic      final_byte;
  rxq_word_t word;

  assign shift_en = busy && !fifo_full;
  assign take     = rx_bit_vld && shift_en;

  rxq_req_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_wr     (req_wr),
    .req_bytes  (req_bytes),
    .byte_done  (byte_done),
    .todo       (todo_bytes),
    .busy       (busy),
    .req_load   (req_load),
    .final_byte (final_byte),
    .done_pulse (rx_done)
  );

  rxq_assembler #(.WORD_BYTES(RXQ_WORD_BYTES), .BYTE_W(RXQ_BYTE_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .bit_in     (rx_bit),
    .final_byte (final_byte),
    .byte_done  (byte_done),
    .push       (fifo_push),
    .word       (word)
  );

  assign fifo_word      = word.data;
  assign fifo_bytes_vld = word.nbytes;

  AST_NO_SHIFT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !shift_en); // R7
  AST_PARTIAL_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push && fifo_bytes_vld != RXQ_BV_W'(RXQ_WORD_BYTES) |-> todo_bytes == '0); // R6
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_load && !fifo_full |=> shift_en || fifo_full); // R2
endmodule

// File: tb/rxq_request_top_test.sv
module rxq_request_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_bytes = '0;
  logic        shift_en;
  logic        rx_bit_vld = 1'b0;
  logic        rx_bit = 1'b0;
  logic        fifo_full = 1'b0;
  logic        fifo_push;
  logic [31:0] fifo_word;
  logic [2:0]  fifo_bytes_vld;
  logic [15:0] todo_bytes;
  logic        rx_done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [31:0] cap_w  [0:15];
  logic [2:0]  cap_bv [0:15];
  int ncap = 0;
  int nirq = 0;

  always #4 clk = ~clk;

  rxq_request_top uut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bytes(req_bytes),
    .shift_en(shift_en), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_word(fifo_word),
    .fifo_bytes_vld(fifo_bytes_vld), .todo_bytes(todo_bytes), .rx_done(rx_done)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_push && ncap < 16) begin
        cap_w[ncap]  = fifo_word;
        cap_bv[ncap] = fifo_bytes_vld;
        ncap++;
      end
      if (rx_done) nirq++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_caps();
    ncap = 0;
    nirq = 0;
  endtask

  task automatic do_req(input logic [15:0] n);
    @(negedge clk);
    req_wr = 1'b1;
    req_bytes = n;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      while (!shift_en) begin
        rx_bit_vld = 1'b0;
        @(negedge clk);
      end
      rx_bit_vld = 1'b1;
      rx_bit = b[i];
    end
    @(negedge clk);
    rx_bit_vld = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    check("R1 todo", 32'(todo_bytes), 32'd0);
    check("R1 shift_en", 32'(shift_en), 32'd0);
    check("R1 push", 32'(fifo_push), 32'd0);
    check("R1 done", 32'(rx_done), 32'd0);
  endtask

  task automatic t_full_words();
    logic [7:0] d [0:7];
    clear_caps();
    for (int i = 0; i < 8; i++) d[i] = 8'h12 + 8'(i * 17);
    do_req(16'd8);
    #1;
    check("R2 load", 32'(todo_bytes), 32'd8);
    check("R2 shift_en", 32'(shift_en), 32'd1);
    for (int i = 0; i < 8; i++) begin
      send_byte(d[i]);
      #1;
      check("R3 todo step", 32'(todo_bytes), 32'(7 - i));
    end
    settle();
    check("R4 word count", 32'(ncap), 32'd2);
    check("R4 word0", cap_w[0], {d[0], d[1], d[2], d[3]});
    check("R4 word1", cap_w[1], {d[4], d[5], d[6], d[7]});
    check("R5 bv0", 32'(cap_bv[0]), 32'd4);
    check("R5 bv1", 32'(cap_bv[1]), 32'd4);
    check("R9 one done", 32'(nirq), 32'd1);
    check("R2 idle after", 32'(shift_en), 32'd0);
  endtask

  task automatic t_partial(input int n);
    logic [7:0] d [0:2];
    logic [31:0] exp;
    clear_caps();
    d[0] = 8'hA5; d[1] = 8'h3C; d[2] = 8'hE1;
    exp = '0;
    do_req(16'(n));
    for (int i = 0; i < n; i++) begin
      send_byte(d[i]);
      exp = {exp[23:0], d[i]};
    end
    #1;
    check("R10 push at last edge", 32'(fifo_push), 32'd1);
    check("R9 done same edge", 32'(rx_done), 32'd1);
    check("R9 todo zero", 32'(todo_bytes), 32'd0);
    @(negedge clk);
    #1;
    check("R10 push one cycle", 32'(fifo_push), 32'd0);
    check("R9 done one cycle", 32'(rx_done), 32'd0);
    settle();
    check("R6 partial word", cap_w[0], exp);
    check("R5 partial bv", 32'(cap_bv[0]), 32'(n));
    check("R9 single pulse", 32'(nirq), 32'd1);
  endtask

  task automatic t_stall();
    clear_caps();
    do_req(16'd2);
    send_byte(8'h5A);
    @(negedge clk);
    fifo_full = 1'b1;
    #1;
    check("R7 shift_en low", 32'(shift_en), 32'd0);
    for (int i = 0; i < 10; i++) begin
      rx_bit_vld = 1'b1;
      rx_bit = 1'b1;
      @(negedge clk);
    end
    rx_bit_vld = 1'b0;
    #1;
    check("R7 todo held", 32'(todo_bytes), 32'd1);
    check("R7 no push", 32'(ncap), 32'd0);
    fifo_full = 1'b0;
    send_byte(8'hC3);
    settle();
    check("R7 word after stall", cap_w[0], 32'h00005AC3);
    check("R7 bv after stall", 32'(cap_bv[0]), 32'd2);
  endtask

  task automatic t_replace();
    clear_caps();
    do_req(16'd10);
    send_byte(8'h11);
    send_byte(8'h22);
    #1;
    check("R3 todo mid", 32'(todo_bytes), 32'd8);
    do_req(16'd3);
    #1;
    check("R8 replaced", 32'(todo_bytes), 32'd3);
    send_byte(8'h33);
    send_byte(8'h44);
    send_byte(8'h55);
    settle();
    check("R8 words", 32'(ncap), 32'd2);
    check("R8 kept lanes", cap_w[0], 32'h11223344);
    check("R8 tail word", cap_w[1], 32'h00000055);
    check("R8 tail bv", 32'(cap_bv[1]), 32'd1);
    check("R9 done once", 32'(nirq), 32'd1);
  endtask

  task automatic t_zero_write();
    clear_caps();
    do_req(16'd0);
    #1;
    check("R2 zero idle todo", 32'(todo_bytes), 32'd0);
    check("R2 zero idle shift", 32'(shift_en), 32'd0);
    do_req(16'hFFFF);
    #1;
    check("R2 max count", 32'(todo_bytes), 32'hFFFF);
    do_req(16'd0);
    #1;
    check("R2 zero ignored", 32'(todo_bytes), 32'hFFFF);
    do_req(16'd1);
    send_byte(8'h7E);
    settle();
    check("R6 single byte", cap_w[0], 32'h0000007E);
    check("R5 single bv", 32'(cap_bv[0]), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_words();
    t_partial(1);
    t_partial(2);
    t_partial(3);
    t_stall();
    t_replace();
    t_zero_write();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule